// File: doc/BRIEF.md
# Fractional Tick Divider with Reference Calibration

The block turns a slow crystal clock, nominally 32768 Hz, into a one-cycle tick at about 1 Hz. The ratio is fractional. An integer divisor N is combined with a 5-bit numerator k, so that k of every 32 output periods last N+1 input cycles and the rest last N. A down counter times each period and reloads at terminal count. A 5-bit error accumulator adds k once per period, and its carry marks the next period as a long one, so the long periods are spread as evenly as the ratio allows. The average ratio is N + k/32, which resolves steps of 1/32 of an input cycle, about 1 ppm at the nominal rate.

N and k can be written directly with a load strobe. They can also be measured. A calibration run counts the input cycles across 32 seconds of an external precision 1 s reference pulse. The integer part of that count over 32 becomes N, and the remainder becomes k. The run is controlled by a four-state machine:

- IDLE (normal running): `cal_start` moves it to ARM.
- ARM (waiting for the first reference pulse, which opens the window): a reference pulse moves it to MEASURE.
- MEASURE (counting cycles and reference pulses): the 32nd pulse after the opening one moves it to COMMIT.
- COMMIT (writing the measured N and k and restarting the divider): it returns to IDLE unconditionally.

The divider keeps ticking with its current settings for the whole run.

Top module: `frac_tick_divider`

## Requirements
- R1: While reset is held, `active_n` reads 32768, `active_frac` reads 0, and both `tick` and `cal_busy` are low.
- R2: A `cfg_load` pulse taken while `cal_busy` is low copies `cfg_n`/`cfg_frac` to `active_n`/`active_frac` at that clock edge and restarts the period. The first tick is then seen N-1 cycles after that edge, and the accumulator starts from zero.
- R3: `tick` is high for exactly one cycle. Consecutive ticks are N or N+1 cycles apart, where N is at least 2.
- R4: Number the periods after a restart 0, 1, 2, and so on. Period 0 lasts N cycles. Period p≥1 lasts N + floor(p·k/32) − floor((p−1)·k/32) cycles, so exactly k of any 32 consecutive periods are N+1 long.
- R5: With k = 0, every period lasts exactly N cycles.
- R6: `cal_start` while idle raises `cal_busy` on the next cycle. `cal_start` during a run has no effect on the measured result.
- R7: A calibration run counts C = the clock edges from the opening reference pulse to the 32nd pulse after it. It then sets `active_n` = C / 32 and `active_frac` = C mod 32, restarts the divider, and drops `cal_busy`. The first tick follows N-1 cycles after the edge that drops `cal_busy`.
- R8: `cfg_load` while `cal_busy` is high, before the commit, leaves `active_n` and `active_frac` unchanged.
- R9: `ref_pulse` while idle leaves `active_n`, `active_frac` and `cal_busy` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-rate clock, divided and counted |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | One-cycle strobe that writes the divisor and numerator |
| cfg_n | input | DIV_W | Integer divisor N to load |
| cfg_frac | input | FRAC_W | Numerator k of long periods per 32 |
| cal_start | input | 1 | Starts a calibration run |
| ref_pulse | input | 1 | One-cycle pulse from the external 1 s reference |
| tick | output | 1 | One-cycle output tick, once per period |
| cal_busy | output | 1 | High from ARM through COMMIT |
| active_n | output | DIV_W | Divisor in use |
| active_frac | output | FRAC_W | Numerator in use |

## Verification
The assertions assume that every divisor ever in force is at least 2. They also assume that the reference pulse and the strobes are single-cycle pulses synchronous to `clk`. The stimulus loads divisors of 8 and up. The reference trains are spaced so that the calibrated divisor is 20 or 37. Every strobe and reference pulse is held for exactly one negative-edge-to-negative-edge interval. Tick spacing is compared against a queue of expected intervals built from the closed-form period formula. Calibration results are compared against the sum of the reference gaps that the bench itself chose.

// File: rtl/ftd_pkg.sv
package ftd_pkg;

    // Calibration sequencer states.
    typedef enum logic [1:0] {
        CAL_IDLE    = 2'd0,
        CAL_ARM     = 2'd1,
        CAL_MEASURE = 2'd2,
        CAL_COMMIT  = 2'd3
    } cal_state_e;

endpackage

// File: rtl/ftd_dither.sv
// Bresenham-style error accumulator: one step per period end, and the carry
// requests a long period next.
module ftd_dither #(
    parameter int FRAC_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [FRAC_W-1:0] frac,
    output logic              long_next
);
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W:0]   sum;

    assign sum       = {1'b0, acc} + {1'b0, frac};
    assign long_next = sum[FRAC_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clear) begin
            acc <= '0;
        end else if (step) begin
            acc <= sum[FRAC_W-1:0];
        end
    end
endmodule

// File: rtl/ftd_countdown.sv
// Period timer: counts down to zero, ticks there, reloads N-1 or N.
module ftd_countdown #(
    parameter int DIV_W = 16,
    parameter int DEF_N = 32768
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] restart_n,
    input  logic [DIV_W-1:0] n_cur,
    input  logic             extend,
    output logic             tick
);
    localparam logic [DIV_W-1:0] ONE        = DIV_W'(1);
    localparam logic [DIV_W-1:0] RESET_LOAD = DIV_W'(DEF_N - 1);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] ext_w;

    assign ext_w = {{(DIV_W-1){1'b0}}, extend};
    assign tick  = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= RESET_LOAD;
        end else if (restart) begin
            cnt <= restart_n - ONE;
        end else if (cnt == '0) begin
            cnt <= n_cur - ONE + ext_w;
        end else begin
            cnt <= cnt - ONE;
        end
    end
endmodule

// File: rtl/ftd_calibrator.sv
// Counts clock cycles across 2**FRAC_W reference seconds and splits the
// total into integer divisor and fractional numerator.
module ftd_calibrator
    import ftd_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_start,
    input  logic              ref_pulse,
    output logic              busy,
    output logic              commit,
    output logic [DIV_W-1:0]  meas_n,
    output logic [FRAC_W-1:0] meas_frac
);
    localparam int                MEAS_W   = DIV_W + FRAC_W;
    localparam logic [FRAC_W-1:0] SECS_MAX = '1;

    cal_state_e        state, state_nx;
    logic [MEAS_W-1:0] meas;
    logic [FRAC_W-1:0] secs;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CAL_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions.
    always_comb begin
        state_nx = state;
        unique case (state)
            CAL_IDLE:    if (cal_start) state_nx = CAL_ARM;
            CAL_ARM:     if (ref_pulse) state_nx = CAL_MEASURE;
            CAL_MEASURE: if (ref_pulse && secs == SECS_MAX) state_nx = CAL_COMMIT;
            CAL_COMMIT:  state_nx = CAL_IDLE;
        endcase
    end

    // Measurement datapath.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meas <= '0;
            secs <= '0;
        end else if (state == CAL_ARM && ref_pulse) begin
            meas <= '0;
            secs <= '0;
        end else if (state == CAL_MEASURE) begin
            meas <= meas + MEAS_W'(1);
            if (ref_pulse) begin
                secs <= secs + FRAC_W'(1);
            end
        end
    end

    // Outputs.
    always_comb begin
        busy      = (state != CAL_IDLE);
        commit    = (state == CAL_COMMIT);
        meas_n    = meas[MEAS_W-1:FRAC_W];
        meas_frac = meas[FRAC_W-1:0];
    end
endmodule

// File: rtl/frac_tick_divider.sv
module frac_tick_divider #(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 5,
    parameter int DEF_N  = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [DIV_W-1:0]  cfg_n,
    input  logic [FRAC_W-1:0] cfg_frac,
    input  logic              cal_start,
    input  logic              ref_pulse,
    output logic              tick,
    output logic              cal_busy,
    output logic [DIV_W-1:0]  active_n,
    output logic [FRAC_W-1:0] active_frac
);
    logic [DIV_W-1:0]  n_reg, cal_n, restart_n;
    logic [FRAC_W-1:0] f_reg, cal_f, restart_f;
    logic              cal_commit, cfg_take, restart, extend, step;

    assign cfg_take  = cfg_load & ~cal_busy;
    assign restart   = cfg_take | cal_commit;
    assign restart_n = cal_commit ? cal_n : cfg_n;
    assign restart_f = cal_commit ? cal_f : cfg_frac;
    assign step      = tick & ~restart;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_reg <= DIV_W'(DEF_N);
            f_reg <= '0;
        end else if (restart) begin
            n_reg <= restart_n;
            f_reg <= restart_f;
        end
    end

    assign active_n    = n_reg;
    assign active_frac = f_reg;

    ftd_calibrator #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_cal (
        .clk       (clk),
        .rst_n     (rst_n),
        .cal_start (cal_start),
        .ref_pulse (ref_pulse),
        .busy      (cal_busy),
        .commit    (cal_commit),
        .meas_n    (cal_n),
        .meas_frac (cal_f)
    );

    ftd_dither #(.FRAC_W(FRAC_W)) u_dither (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (restart),
        .step      (step),
        .frac      (f_reg),
        .long_next (extend)
    );

    ftd_countdown #(.DIV_W(DIV_W), .DEF_N(DEF_N)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .restart_n (restart_n),
        .n_cur     (n_reg),
        .extend    (extend),
        .tick      (tick)
    );
endmodule

// File: rtl/ftd_checker.sv
module ftd_checker #(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              cfg_load,
    input logic              cal_start,
    input logic              cal_busy,
    input logic              cal_commit,
    input logic [DIV_W-1:0]  active_n,
    input logic [FRAC_W-1:0] active_frac
);
    logic [DIV_W:0] gap;
    logic           restart_seen;

    assign restart_seen = (cfg_load && !cal_busy) || cal_commit;

    // Cycles since the last tick or restart.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap <= '0;
        end else if (tick || restart_seen) begin
            gap <= '0;
        end else begin
            gap <= gap + 1'b1;
        end
    end

    p_tick_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    p_gap_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        gap <= {1'b0, active_n});

    p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cal_busy && cal_start) |=> cal_busy);

    p_commit_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cal_commit |=> !cal_busy);

    p_cfg_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && cal_busy && !cal_commit) |=> ($stable(active_n) && $stable(active_frac)));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cal_busy && !cfg_load) |=> ($stable(active_n) && $stable(active_frac)));
endmodule

bind frac_tick_divider ftd_checker #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .cfg_load    (cfg_load),
    .cal_start   (cal_start),
    .cal_busy    (cal_busy),
    .cal_commit  (cal_commit),
    .active_n    (active_n),
    .active_frac (active_frac)
);

// File: tb/frac_tick_divider_test.sv
`timescale 1ns/1ps
module frac_tick_divider_test;
    localparam int DIV_W  = 16;
    localparam int FRAC_W = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_load = 1'b0;
    logic [DIV_W-1:0]  cfg_n = '0;
    logic [FRAC_W-1:0] cfg_frac = '0;
    logic              cal_start = 1'b0;
    logic              ref_pulse = 1'b0;
    logic              tick;
    logic              cal_busy;
    logic [DIV_W-1:0]  active_n;
    logic [FRAC_W-1:0] active_frac;

    int    checks = 0;
    int    failures = 0;
    longint cyc = 0;
    longint mark = 0;
    bit    prev_tick = 1'b0;
    bit    done = 1'b0;
    int    exp_q[$];
    string tag_q[$];

    frac_tick_divider #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_n(cfg_n),
        .cfg_frac(cfg_frac), .cal_start(cal_start), .ref_pulse(ref_pulse),
        .tick(tick), .cal_busy(cal_busy), .active_n(active_n),
        .active_frac(active_frac)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc = cyc + 1;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Period p>=1 after a restart, from the requirement's closed form.
    function automatic int plen(input int n, input int k, input int p);
        return n + (p * k) / 32 - ((p - 1) * k) / 32;
    endfunction

    task automatic push_run(input int n, input int k, input int periods, input string tag);
        exp_q.push_back(n - 1);
        tag_q.push_back({tag, " first tick"});
        for (int p = 1; p <= periods; p++) begin
            exp_q.push_back(plen(n, k, p));
            tag_q.push_back(tag);
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic do_load(input int n, input int k, input int periods, input string tag);
        @(negedge clk);
        cfg_n = DIV_W'(n);
        cfg_frac = FRAC_W'(k);
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        mark = cyc;
        check(active_n == DIV_W'(n) && active_frac == FRAC_W'(k), "R2 load value",
              active_n, n);
        push_run(n, k, periods, tag);
        drain();
    endtask

    task automatic pulse_ref();
        ref_pulse = 1'b1;
        @(negedge clk);
        ref_pulse = 1'b0;
    endtask

    // Opening pulse, then 32 gaps; the first n_long gaps are base+1.
    task automatic ref_train(input int base, input int n_long, input bit poke_start);
        pulse_ref();
        for (int i = 0; i < 32; i++) begin
            int gap_len;
            gap_len = (i < n_long) ? base + 1 : base;
            for (int j = 0; j < gap_len - 1; j++) begin
                if (poke_start && i == 10 && j == 3) cal_start = 1'b1;
                else cal_start = 1'b0;
                @(negedge clk);
            end
            cal_start = 1'b0;
            pulse_ref();
        end
    endtask

    task automatic run_cal(input int base, input int n_long, input bit poke_start,
                           input int periods);
        int total;
        total = 32 * base + n_long;
        @(negedge clk);
        cal_start = 1'b1;
        @(negedge clk);
        cal_start = 1'b0;
        check(cal_busy == 1'b1, "R6 busy after start", cal_busy, 1);
        ref_train(base, n_long, poke_start);
        do @(negedge clk); while (cal_busy);
        mark = cyc;
        check(active_n == DIV_W'(total / 32), "R7 calibrated divisor", active_n, total / 32);
        check(active_frac == FRAC_W'(total % 32), "R7 calibrated numerator",
              active_frac, total % 32);
        push_run(total / 32, total % 32, periods, "R7");
        drain();
    endtask

    // Scoreboard monitor.
    always @(negedge clk) begin
        if (rst_n && tick) begin
            check(!prev_tick, "R3 one-cycle tick", prev_tick, 0);
            if (exp_q.size() > 0) begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(cyc - mark == e, t, cyc - mark, e);
            end
            mark = cyc;
        end
        prev_tick = rst_n && tick;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R3 watchdog expired actual=%0d expected=finished", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(active_n == 16'd32768, "R1 reset divisor", active_n, 32768);
        check(active_frac == '0, "R1 reset numerator", active_frac, 0);
        check(tick == 1'b0, "R1 reset tick", tick, 0);
        check(cal_busy == 1'b0, "R1 reset busy", cal_busy, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: integer ratio
        do_load(10, 0, 6, "R5");
        // R4: sparse and dense fractions
        do_load(12, 5, 40, "R4");
        do_load(8, 31, 40, "R4");

        // R9: reference pulses while idle
        for (int i = 0; i < 3; i++) begin
            pulse_ref();
            repeat (4) @(negedge clk);
        end
        check(active_n == 16'd8 && active_frac == 5'd31, "R9 idle ref divisor", active_n, 8);
        check(cal_busy == 1'b0, "R9 idle ref busy", cal_busy, 0);

        // R8: a load during ARM is dropped
        @(negedge clk);
        cal_start = 1'b1;
        @(negedge clk);
        cal_start = 1'b0;
        check(cal_busy == 1'b1, "R6 busy after start", cal_busy, 1);
        cfg_n = 16'd99;
        cfg_frac = 5'd3;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        @(negedge clk);
        check(active_n == 16'd8, "R8 load ignored divisor", active_n, 8);
        check(active_frac == 5'd31, "R8 load ignored numerator", active_frac, 31);
        // Finish this run with a fractional reference: 32*37+5 = 1189.
        ref_train(37, 5, 1'b1);
        do @(negedge clk); while (cal_busy);
        mark = cyc;
        check(active_n == 16'd37, "R7 calibrated divisor", active_n, 37);
        check(active_frac == 5'd5, "R7 calibrated numerator (R6 restart ignored)",
              active_frac, 5);
        push_run(37, 5, 40, "R7");
        drain();

        // Second run with an even reference: 32*20 = 640.
        run_cal(20, 0, 1'b0, 10);

        // R2 again after calibration.
        do_load(9, 16, 34, "R2");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule